// File: doc/BRIEF.md
# Strobe-Triggered Sampler Data Source

This block is the device end of an 8-bit audio sampler that hangs off a host's parallel port. The host reads the port's data byte. After each read it pulses a strobe line. The block treats every rising edge of that strobe as the order to start the next conversion. It asks an upstream sample source for a new value through a request/valid handshake. When the value arrives, the block drives it onto the parallel data lines, where it waits for the host's following read.

Because the strobe only comes after a read, the byte a read returns always belongs to the conversion started by the read before it. The block is therefore a one-deep pipeline clocked by the host's polling rate, and there is no sample clock inside it. Until the first conversion finishes, the data lines carry a fixed idle value, so the host's first read after start-up returns that idle value.

Top module: `strobe_sampler`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the data lines to the idle value (0x00 by default), drops smp_req, and clears data_ready and overrun.
- R2: The strobe passes through a two-flop synchronizer. A low-to-high strobe change that is stable before clock edge k raises smp_req after edge k+2, provided no conversion is pending.
- R3: smp_req stays high until a cycle in which smp_valid is high. At that edge, pdata takes smp_data and smp_req falls, unless R7 applies.
- R4: pdata changes only at an edge where smp_req and smp_valid are both high. smp_valid while no request is pending is ignored.
- R5: data_ready is 1 once a conversion has completed and no newer one is pending. An accepted strobe edge clears it, and it stays 0 until that conversion completes.
- R6: A strobe edge taken while a conversion is pending, in a cycle without smp_valid, sets overrun. overrun stays set until reset. That edge starts no second request, so the single pending request is still ended by one smp_valid.
- R7: If a strobe edge takes effect in the same cycle as smp_valid on a pending request, the sample is captured and a new request starts at once: smp_req stays high, data_ready stays 0, and overrun is not set.
- R8: Strobe edges that occur before the first completion leave pdata at the idle value.
- R9: Only a low-to-high strobe change counts. A strobe held high, or a falling strobe, starts no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_in | input | 1 | Host strobe, asynchronous to clk |
| smp_req | output | 1 | Conversion request to the sample source |
| smp_valid | input | 1 | Sample source result valid, one cycle |
| smp_data | input | DATA_W (8) | Sample value from the source |
| pdata | output | DATA_W (8) | Parallel data lines seen by the host |
| data_ready | output | 1 | Lines hold the latest requested sample |
| overrun | output | 1 | Sticky flag: a strobe edge arrived while a conversion was pending |

## Verification
A synchronized strobe edge can act in the same cycle that the source returns a sample for the pending request. The block then has to complete one conversion and open the next in that single cycle. The bench produces this case on purpose. It raises the strobe so that its synchronized edge falls on the cycle in which smp_valid is driven, and it also produces the case at random. It judges the result on the following cycle: pdata must hold the new sample, smp_req must still be high, data_ready must be 0, and overrun must be unchanged. The case where the edge comes one cycle earlier, without smp_valid, is run next to it and must set overrun.

// File: rtl/strobe_sampler_pkg.sv
package strobe_sampler_pkg;
   typedef enum logic {
      CONV_IDLE = 1'b0,
      CONV_BUSY = 1'b1
   } conv_state_e;
endpackage

// File: rtl/sampler_sync_edge.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module sampler_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sampler_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[LAST];
      end
   end

   assign rise_o = chain_q[LAST] & ~last_q;
endmodule

// File: rtl/sampler_req_ctl.sv
// Request / completion / overrun control for one outstanding conversion.
module sampler_req_ctl
   import strobe_sampler_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic rise_i,
   input  logic valid_i,
   output logic req_o,
   output logic load_o,
   output logic ready_o,
   output logic overrun_o
);
   conv_state_e state_q;
   logic        ready_q;
   logic        ovr_q;

   assign load_o = (state_q == CONV_BUSY) && valid_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= CONV_IDLE;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (rise_i) begin
         if ((state_q == CONV_BUSY) && !valid_i) begin
            ovr_q <= 1'b1;
         end else begin
            state_q <= CONV_BUSY;
            ready_q <= 1'b0;
         end
      end else if (load_o) begin
         state_q <= CONV_IDLE;
         ready_q <= 1'b1;
      end
   end

   assign req_o     = (state_q == CONV_BUSY);
   assign ready_o   = ready_q;
   assign overrun_o = ovr_q;
endmodule

// File: rtl/sampler_data_hold.sv
// Output data register: idle value after reset, loads only on completion.
module sampler_data_hold #(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] IDLE_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sampler_data_hold: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)         dout_o <= IDLE_VALUE;
      else if (load_i) dout_o <= din_i;
   end
endmodule

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] IDLE_VALUE  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe_in,
   output logic              smp_req,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic [DATA_W-1:0] pdata,
   output logic              data_ready,
   output logic              overrun
);
   logic strobe_rise;
   logic load_en;

   sampler_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst      (rst),
      .async_in (strobe_in),
      .rise_o   (strobe_rise)
   );

   sampler_req_ctl ctl_i (
      .clk       (clk),
      .rst       (rst),
      .rise_i    (strobe_rise),
      .valid_i   (smp_valid),
      .req_o     (smp_req),
      .load_o    (load_en),
      .ready_o   (data_ready),
      .overrun_o (overrun)
   );

   sampler_data_hold #(.DATA_W(DATA_W), .IDLE_VALUE(IDLE_VALUE)) hold_i (
      .clk    (clk),
      .rst    (rst),
      .load_i (load_en),
      .din_i  (smp_data),
      .dout_o (pdata)
   );
endmodule

// File: rtl/strobe_sampler_checker.sv
module strobe_sampler_checker #(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] IDLE_VALUE = '0
) (
   input logic              clk,
   input logic              rst,
   input logic              rise,
   input logic              smp_req,
   input logic              smp_valid,
   input logic [DATA_W-1:0] smp_data,
   input logic [DATA_W-1:0] pdata,
   input logic              data_ready,
   input logic              overrun
);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (pdata == IDLE_VALUE && !smp_req && !data_ready && !overrun));

   a_r2_edge_starts_req: assert property (@(posedge clk) disable iff (rst)
      (rise && !smp_req) |=> smp_req);

   a_r3_req_waits: assert property (@(posedge clk) disable iff (rst)
      (smp_req && !smp_valid) |=> smp_req);

   a_r3_capture: assert property (@(posedge clk) disable iff (rst)
      (smp_req && smp_valid) |=> (pdata == $past(smp_data)));

   a_r3_req_ends: assert property (@(posedge clk) disable iff (rst)
      (smp_req && smp_valid && !rise) |=> (!smp_req && data_ready));

   a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
      !(smp_req && smp_valid) |=> $stable(pdata));

   a_r5_ready_excl: assert property (@(posedge clk) disable iff (rst)
      !(smp_req && data_ready));

   a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun);

   a_r6_overrun_set: assert property (@(posedge clk) disable iff (rst)
      (rise && smp_req && !smp_valid) |=> (overrun && smp_req));

   a_r6_overrun_cause: assert property (@(posedge clk) disable iff (rst)
      (!overrun && !(rise && smp_req && !smp_valid)) |=> !overrun);

   a_r7_back_to_back: assert property (@(posedge clk) disable iff (rst)
      (rise && smp_req && smp_valid) |=> (smp_req && !data_ready));
endmodule

bind strobe_sampler strobe_sampler_checker #(
   .DATA_W     (DATA_W),
   .IDLE_VALUE (IDLE_VALUE)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .rise       (strobe_rise),
   .smp_req    (smp_req),
   .smp_valid  (smp_valid),
   .smp_data   (smp_data),
   .pdata      (pdata),
   .data_ready (data_ready),
   .overrun    (overrun)
);

// File: tb/strobe_sampler_tb_top.sv
`timescale 1ns/1ps
module strobe_sampler_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         strobe_in = 1'b0;
   logic         smp_valid = 1'b0;
   logic [W-1:0] smp_data = '0;
   logic         smp_req;
   logic [W-1:0] pdata;
   logic         data_ready;
   logic         overrun;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bench model of the requirements
   bit         m_s0, m_s1, m_sp;
   bit         m_pend, m_ready, m_ovr;
   logic [W-1:0] m_data;

   always #5 clk = ~clk;

   strobe_sampler dut_i (
      .clk(clk), .rst(rst), .strobe_in(strobe_in), .smp_req(smp_req),
      .smp_valid(smp_valid), .smp_data(smp_data), .pdata(pdata),
      .data_ready(data_ready), .overrun(overrun)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic void model_reset();
      m_s0 = 0; m_s1 = 0; m_sp = 0;
      m_pend = 0; m_ready = 0; m_ovr = 0; m_data = '0;
   endfunction

   function automatic void model_edge(input bit stb, input bit vld, input logic [W-1:0] d);
      bit rise_m;
      rise_m = m_s1 & ~m_sp;
      if (m_pend && vld) begin
         m_data = d; m_pend = 0; m_ready = 1;
      end
      if (rise_m) begin
         if (m_pend && !vld) m_ovr = 1;
         else begin m_pend = 1; m_ready = 0; end
      end
      m_sp = m_s1; m_s1 = m_s0; m_s0 = stb;
   endfunction

   // drive at negedge, clock one edge, compare at the following negedge
   task automatic step(input bit stb, input bit vld, input logic [W-1:0] d);
      strobe_in = stb; smp_valid = vld; smp_data = d;
      @(posedge clk);
      if (rst) model_reset(); else model_edge(stb, vld, d);
      @(negedge clk);
      check("R2 smp_req", smp_req, m_pend);
      check("R4 pdata", pdata, m_data);
      check("R5 data_ready", data_ready, m_ready);
      check("R6 overrun", overrun, m_ovr);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step(0, 0, '0);
      step(0, 0, '0);
      rst = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17_0C3D));
      model_reset();
      @(negedge clk);
      do_reset();
      // R1: reset state
      check("R1 pdata idle", pdata, 8'h00);
      check("R1 req low", smp_req, 0);
      check("R1 ready low", data_ready, 0);
      check("R1 overrun low", overrun, 0);

      // R2: request appears after the third edge
      step(1, 0, '0);
      check("R2 no req after edge 1", smp_req, 0);
      step(1, 0, '0);
      check("R2 no req after edge 2", smp_req, 0);
      step(1, 0, '0);
      check("R2 req after edge 3", smp_req, 1);
      // R8: still idle before first completion
      check("R8 idle before completion", pdata, 8'h00);
      step(1, 0, '0);
      // R3: completion
      step(1, 1, 8'hA5);
      check("R3 pdata captured", pdata, 8'hA5);
      check("R3 req dropped", smp_req, 0);
      check("R5 ready set", data_ready, 1);
      // R9: held-high strobe starts nothing
      for (int i = 0; i < 5; i++) step(1, 0, '0);
      check("R9 held strobe no req", smp_req, 0);
      step(0, 0, '0); step(0, 0, '0); step(0, 0, '0);
      check("R9 falling strobe no req", smp_req, 0);
      // R4: valid without request ignored
      step(0, 1, 8'h3C);
      check("R4 stray valid ignored", pdata, 8'hA5);

      // R6: second edge while pending
      step(1, 0, '0); step(0, 0, '0); step(0, 0, '0);
      check("R5 ready cleared on request", data_ready, 0);
      step(1, 0, '0); step(0, 0, '0); step(0, 0, '0);
      check("R6 overrun set", overrun, 1);
      check("R6 still one req", smp_req, 1);
      step(0, 1, 8'h11);
      check("R6 single valid ends req", smp_req, 0);
      check("R6 overrun sticky", overrun, 1);

      // R7: edge and completion in the same cycle
      do_reset();
      step(1, 0, '0); step(0, 0, '0); step(0, 0, '0);   // req up
      step(1, 0, '0); step(0, 0, '0);                   // rise acts at next edge
      step(0, 1, 8'h77);
      check("R7 data captured", pdata, 8'h77);
      check("R7 req stays high", smp_req, 1);
      check("R7 ready stays low", data_ready, 0);
      check("R7 no overrun", overrun, 0);
      step(0, 1, 8'h78);
      check("R7 second sample", pdata, 8'h78);

      // constrained random traffic against the model
      do_reset();
      begin
         bit s = 0;
         for (int n = 0; n < 4000; n++) begin
            bit v;
            if (($urandom % 4) == 0) s = ~s;
            v = m_pend && (($urandom % 3) == 0);
            if (($urandom % 200) == 0) do_reset();
            else step(s, v ? 1'b1 : (($urandom % 10) == 0), W'($urandom));
         end
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule